// File: doc/BRIEF.md
# Receive Parity and CRC Integrity Checker

This block watches bytes arriving from a SCSI-style parallel bus and flags corrupted data. It works the same way whether the local side is acting as initiator or as target. For asynchronous and single-transition synchronous transfers it checks each strobed byte against its parity bit, using odd parity. For double-transition synchronous transfers it runs a CRC-32 over the strobed bytes and compares the result with the word the far end supplies. The compare happens only when the target asks for a CRC exchange.

Any detected error sets a sticky status flag. The flag drives an interrupt request through a mask enable. Parity reporting and CRC reporting have separate controls. When the local side is the initiator, an error can also raise an attention request to the far end. Attention is optional and has its own enable. Raising attention does not halt the transfer. It stays raised until the next bus phase change.

Top module: `rx_integrity_check`

## Requirements
- R1: Mode encoding on `xfer_mode`: 2'b00 asynchronous, 2'b01 single-transition synchronous, 2'b1x double-transition synchronous. In the first two modes, when `chk_en` is 1, a strobed byte whose nine bits (`rx_byte` plus `rx_par`) hold an even number of ones is a parity error. The error sets `err_status` at the clock edge that takes the strobe. This applies in both roles.
- R2: When `chk_en` is 0, parity errors are ignored and `err_status` is left unchanged.
- R3: In double-transition mode no parity check is made. Each strobed byte is folded into a CRC-32 accumulator: MSB first, polynomial 0x04C11DB7, seeded to all ones, no reflection and no final inversion. The ASCII bytes "123456789" give 0x0376E6E7. When `crc_req` is high, the accumulator is compared with `crc_word`, and a mismatch sets `err_status`. A byte strobed in the same cycle as `crc_req` is not folded in. `crc_req` has no effect outside double-transition mode.
- R4: CRC mismatches are reported whatever the value of `chk_en`. When `crc_dis` is 1, a mismatch is not reported.
- R5: The accumulator returns to its seed after each CRC compare and on every `phase_chg` pulse. `phase_chg` takes priority over a byte strobed in the same cycle.
- R6: `err_status` is sticky. It clears only on a `status_clr` pulse. A new error in the same cycle as the clear leaves it set.
- R7: `irq` is high exactly when `err_status` and `irq_en` are both 1.
- R8: In initiator role (`is_initiator`=1) with `atn_en`=1, an error raises `atn` at the same edge that sets the status. `atn` then stays high until a `phase_chg` pulse and is not affected by `status_clr`. When `atn_en` is 0, `atn` stays low.
- R9: In target role, errors still set `err_status` but never raise `atn`.
- R10: After synchronous reset (`rst_n`=0 at a clock edge), `err_status`, `irq` and `atn` are 0 and the accumulator holds its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | DATA_W | Received data byte |
| rx_par | input | 1 | Received parity bit |
| rx_stb | input | 1 | Byte strobe, one cycle per byte |
| xfer_mode | input | 2 | Transfer mode (see R1) |
| is_initiator | input | 1 | 1 = initiator role, 0 = target role |
| crc_req | input | 1 | Target requests CRC compare |
| crc_word | input | CRC_W | CRC value received from the bus |
| chk_en | input | 1 | Parity check enable |
| crc_dis | input | 1 | CRC check disable |
| atn_en | input | 1 | Allow errors to raise attention |
| irq_en | input | 1 | Interrupt mask enable |
| status_clr | input | 1 | Read-to-clear strobe for the status flag |
| phase_chg | input | 1 | Bus phase change pulse |
| err_status | output | 1 | Sticky error flag |
| irq | output | 1 | Interrupt request |
| atn | output | 1 | Attention request to the target |

## Verification
The bench builds the block with its defaults: an 8-bit data path and the 32-bit CRC with polynomial 0x04C11DB7 and an all-ones seed. These values put the well-known "123456789" check value within reach as an expected result that does not depend on the RTL. The bench uses that value to confirm CRC accumulation, the reseed after a compare, and the reseed on a phase change. The same defaults make every parity case one nine-bit pattern, so a short vector table covers each mode and enable combination.

// File: rtl/rx_check_pkg.sv
// Package: shared constants and the CRC step function for the receive checker.
// Assumes CRC is computed MSB first, non-reflected.
package rx_check_pkg;

    // Transfer-mode encoding; bit 1 set means double-transition.
    localparam logic [1:0] XM_ASYNC = 2'b00;
    localparam logic [1:0] XM_ST    = 2'b01;
    localparam logic [1:0] XM_DT    = 2'b10;

    // Decode whether a mode value selects double-transition transfers.
    function automatic logic mode_is_dt(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/rx_parity_chk.sv
// Parity checker: flags a strobed byte whose data-plus-parity bits do not
// have odd weight. Active only in non-DT modes with checking enabled.
// Assumes rx_stb is a single-cycle pulse per byte.
module rx_parity_chk #(
    parameter int DATA_W = 8
) (
    input  logic              rx_stb,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_par,
    input  logic              dt_mode,
    input  logic              chk_en,
    output logic              par_err
);
    // Combinational odd-parity test on the strobed byte.
    always_comb begin
        par_err = rx_stb && chk_en && !dt_mode && !(^{rx_byte, rx_par});
    end

    // R3: parity is never flagged in double-transition mode.
    always_comb begin
        assert_no_par_in_dt_R3: assert (!(dt_mode && par_err));
    end
endmodule

// File: rtl/rx_crc_acc.sv
// CRC accumulator: folds strobed bytes into a CRC in DT mode and compares
// with the received word when the target requests it. Reseeds after each
// compare and on a phase change. Assumes a byte strobed together with a
// compare request or phase change is dropped.
module rx_crc_acc
    import rx_check_pkg::*;
#(
    parameter int              DATA_W = 8,
    parameter int              CRC_W  = 32,
    parameter logic [CRC_W-1:0] POLY  = 32'h04C1_1DB7,
    parameter logic [CRC_W-1:0] SEED  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dt_mode,
    input  logic              rx_stb,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              crc_req,
    input  logic [CRC_W-1:0]  crc_word,
    input  logic              crc_dis,
    input  logic              phase_chg,
    output logic              crc_err
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;
    logic             do_check;

    // Step the CRC one data bit at a time, MSB first.
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_q;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ rx_byte[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        crc_next = c;
    end

    // Compare request is valid only in DT mode.
    always_comb begin
        do_check = crc_req && dt_mode;
        crc_err  = do_check && !crc_dis && (crc_word != crc_q);
    end

    // Accumulator register: reseed on reset, compare or phase change.
    always_ff @(posedge clk) begin
        if (!rst_n || phase_chg || do_check) begin
            crc_q <= SEED;
        end else if (rx_stb && dt_mode) begin
            crc_q <= crc_next;
        end
    end

    // R5: after a phase change the accumulator is back at its seed.
    assert_reseed_on_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_chg |=> (crc_q == SEED));

    // R4: a disabled CRC check never reports.
    assert_crc_dis_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        crc_dis |-> !crc_err);
endmodule

// File: rtl/rx_err_report.sv
// Error reporting: sticky status flag, masked interrupt and optional
// attention request. Assumes err_evt is a single-cycle event.
module rx_err_report (
    input  logic clk,
    input  logic rst_n,
    input  logic err_evt,
    input  logic status_clr,
    input  logic irq_en,
    input  logic is_initiator,
    input  logic atn_en,
    input  logic phase_chg,
    output logic err_status,
    output logic irq,
    output logic atn
);
    // Sticky status: a new error wins over the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          err_status <= 1'b0;
        else if (err_evt)    err_status <= 1'b1;
        else if (status_clr) err_status <= 1'b0;
    end

    // Attention: raised by initiator-side errors, dropped on phase change.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  atn <= 1'b0;
        else if (err_evt && is_initiator && atn_en)  atn <= 1'b1;
        else if (phase_chg)                          atn <= 1'b0;
    end

    // Interrupt output is the status gated by the mask enable.
    always_comb begin
        irq = err_status && irq_en;
    end

    // R6: status stays set unless cleared.
    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status && !status_clr) |=> err_status);

    // R6: status only rises because an error occurred.
    assert_status_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_status) |-> $past(err_evt));

    // R9: attention is only raised in initiator role.
    assert_atn_initiator_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(atn) |-> $past(is_initiator));

    // R8: attention holds until a phase change.
    assert_atn_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (atn && !phase_chg) |=> atn);
endmodule

// File: rtl/rx_integrity_check.sv
// Top: receive integrity checker. Combines per-byte parity checking
// (asynchronous / single-transition modes) with target-triggered CRC
// checking (double-transition mode), and reports through a sticky flag,
// masked interrupt and optional attention. Synchronous active-low reset.
module rx_integrity_check
    import rx_check_pkg::*;
#(
    parameter int               DATA_W = 8,
    parameter int               CRC_W  = 32,
    parameter logic [CRC_W-1:0] POLY   = 32'h04C1_1DB7,
    parameter logic [CRC_W-1:0] SEED   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_par,
    input  logic              rx_stb,
    input  logic [1:0]        xfer_mode,
    input  logic              is_initiator,
    input  logic              crc_req,
    input  logic [CRC_W-1:0]  crc_word,
    input  logic              chk_en,
    input  logic              crc_dis,
    input  logic              atn_en,
    input  logic              irq_en,
    input  logic              status_clr,
    input  logic              phase_chg,
    output logic              err_status,
    output logic              irq,
    output logic              atn
);
    logic dt_mode;
    logic par_err;
    logic crc_err;
    logic err_evt;

    // Decode mode and merge the two error sources.
    always_comb begin
        dt_mode = mode_is_dt(xfer_mode);
        err_evt = par_err || crc_err;
    end

    rx_parity_chk #(.DATA_W(DATA_W)) u_par (
        .rx_stb  (rx_stb),
        .rx_byte (rx_byte),
        .rx_par  (rx_par),
        .dt_mode (dt_mode),
        .chk_en  (chk_en),
        .par_err (par_err)
    );

    rx_crc_acc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .dt_mode   (dt_mode),
        .rx_stb    (rx_stb),
        .rx_byte   (rx_byte),
        .crc_req   (crc_req),
        .crc_word  (crc_word),
        .crc_dis   (crc_dis),
        .phase_chg (phase_chg),
        .crc_err   (crc_err)
    );

    rx_err_report u_rep (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_evt      (err_evt),
        .status_clr   (status_clr),
        .irq_en       (irq_en),
        .is_initiator (is_initiator),
        .atn_en       (atn_en),
        .phase_chg    (phase_chg),
        .err_status   (err_status),
        .irq          (irq),
        .atn          (atn)
    );

    // R2: with checking off, a non-DT strobe cannot raise the status.
    assert_par_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_en && !dt_mode && !err_status && !crc_req) |=> !err_status);
endmodule

// File: tb/test_rx_integrity_check.sv
// Bench: a parity vector table walked by a loop, then directed tests for
// reset, CRC, reporting and attention corner cases.
module test_rx_integrity_check;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int CRC_W  = 32;
    localparam logic [31:0] CHECK_VAL = 32'h0376_E6E7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] rx_byte = '0;
    logic              rx_par = 1'b0;
    logic              rx_stb = 1'b0;
    logic [1:0]        xfer_mode = 2'b00;
    logic              is_initiator = 1'b1;
    logic              crc_req = 1'b0;
    logic [CRC_W-1:0]  crc_word = '0;
    logic              chk_en = 1'b1;
    logic              crc_dis = 1'b0;
    logic              atn_en = 1'b0;
    logic              irq_en = 1'b0;
    logic              status_clr = 1'b0;
    logic              phase_chg = 1'b0;
    logic              err_status, irq, atn;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_integrity_check i_rx_integrity_check (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_par(rx_par),
        .rx_stb(rx_stb), .xfer_mode(xfer_mode), .is_initiator(is_initiator),
        .crc_req(crc_req), .crc_word(crc_word), .chk_en(chk_en),
        .crc_dis(crc_dis), .atn_en(atn_en), .irq_en(irq_en),
        .status_clr(status_clr), .phase_chg(phase_chg),
        .err_status(err_status), .irq(irq), .atn(atn)
    );

    // Parity vectors: {byte[12:5], par[4], mode[3:2], chk_en[1], expect_err[0]}
    localparam logic [12:0] VEC [8] = '{
        {8'h00, 1'b1, 2'b00, 1'b1, 1'b0},
        {8'h00, 1'b0, 2'b00, 1'b1, 1'b1},
        {8'h01, 1'b0, 2'b01, 1'b1, 1'b0},
        {8'h03, 1'b0, 2'b01, 1'b1, 1'b1},
        {8'hFF, 1'b0, 2'b00, 1'b0, 1'b0},
        {8'h7F, 1'b0, 2'b00, 1'b1, 1'b0},
        {8'hA5, 1'b1, 2'b10, 1'b1, 1'b0},
        {8'h80, 1'b1, 2'b11, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic p);
        @(negedge clk);
        rx_byte = b; rx_par = p; rx_stb = 1'b1;
        @(negedge clk);
        rx_stb = 1'b0;
    endtask

    task automatic clear_status();
        @(negedge clk) status_clr = 1'b1;
        @(negedge clk) status_clr = 1'b0;
    endtask

    task automatic pulse_phase();
        @(negedge clk) phase_chg = 1'b1;
        @(negedge clk) phase_chg = 1'b0;
    endtask

    task automatic send_check_string();
        string s = "123456789";
        for (int k = 0; k < 9; k++) send_byte(s[k], 1'b0);
    endtask

    task automatic request_crc(input logic [31:0] w);
        @(negedge clk);
        crc_req = 1'b1; crc_word = w;
        @(negedge clk);
        crc_req = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        // R10: reset state
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 status", err_status, 1'b0);
        chk("R10 atn", atn, 1'b0);
        chk("R10 irq", irq, 1'b0);

        // R1 / R2 / R3: parity vector table
        for (int v = 0; v < 8; v++) begin
            xfer_mode = VEC[v][3:2];
            chk_en    = VEC[v][1];
            clear_status();
            send_byte(VEC[v][12:5], VEC[v][4]);
            chk($sformatf("R1/R2/R3 vector %0d", v), err_status, VEC[v][0]);
        end
        chk_en = 1'b1;

        // R3: correct CRC over check string gives no error
        do_reset();
        xfer_mode = 2'b10;
        send_check_string();
        request_crc(CHECK_VAL);
        chk("R3 crc match", err_status, 1'b0);

        // R5: reseeded after compare, same string matches again
        send_check_string();
        request_crc(CHECK_VAL);
        chk("R5 reseed after compare", err_status, 1'b0);

        // R3: mismatch is reported
        send_check_string();
        request_crc(CHECK_VAL ^ 32'h1);
        chk("R3 crc mismatch", err_status, 1'b1);

        // R5: phase change discards partial data
        clear_status();
        send_byte("1", 1'b0);
        send_byte("2", 1'b0);
        pulse_phase();
        send_check_string();
        request_crc(CHECK_VAL);
        chk("R5 reseed on phase change", err_status, 1'b0);

        // R4: CRC reported even with chk_en off; suppressed by crc_dis
        chk_en = 1'b0;
        request_crc(32'hDEAD_BEEF);
        chk("R4 crc with chk_en off", err_status, 1'b1);
        clear_status();
        crc_dis = 1'b1;
        request_crc(32'hDEAD_BEEF);
        chk("R4 crc_dis suppresses", err_status, 1'b0);
        crc_dis = 1'b0;
        chk_en = 1'b1;

        // R3: crc_req ignored outside DT mode
        xfer_mode = 2'b00;
        request_crc(32'hDEAD_BEEF);
        chk("R3 crc_req ignored in async", err_status, 1'b0);

        // R7: interrupt masking
        send_byte(8'h00, 1'b0);
        irq_en = 1'b0; #1;
        chk("R7 irq masked", irq, 1'b0);
        irq_en = 1'b1; #1;
        chk("R7 irq unmasked", irq, 1'b1);

        // R6: sticky, and error wins over clear in the same cycle
        repeat (3) @(negedge clk);
        chk("R6 sticky", err_status, 1'b1);
        @(negedge clk);
        rx_byte = 8'h00; rx_par = 1'b0; rx_stb = 1'b1; status_clr = 1'b1;
        @(negedge clk);
        rx_stb = 1'b0; status_clr = 1'b0;
        chk("R6 set wins over clear", err_status, 1'b1);
        clear_status();
        chk("R6 clear", err_status, 1'b0);

        // R8: attention off when atn_en is 0
        is_initiator = 1'b1; atn_en = 1'b0;
        send_byte(8'h00, 1'b0);
        chk("R8 atn disabled", atn, 1'b0);

        // R8: attention raised, survives status clear, dropped on phase change
        atn_en = 1'b1;
        clear_status();
        send_byte(8'h00, 1'b0);
        chk("R8 atn raised", atn, 1'b1);
        clear_status();
        chk("R8 atn holds over clear", atn, 1'b1);
        pulse_phase();
        chk("R8 atn dropped on phase", atn, 1'b0);

        // R9: target role records the error but never raises attention
        is_initiator = 1'b0;
        clear_status();
        send_byte(8'h00, 1'b0);
        chk("R9 target status", err_status, 1'b1);
        chk("R9 target no atn", atn, 1'b0);

        // R10: reset clears sticky state
        do_reset();
        #1;
        chk("R10 status after reset", err_status, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule